// File: doc/BRIEF.md
# Per-Peer Antenna Weight Table

This block sits inside a MAC transmit/receive accelerator. It keeps a small, fully associative table of RF antenna weight sets, one entry per peer station, keyed by the peer's 48-bit MAC address. Each entry holds a valid flag, the peer's antenna count (1 to 4) and four complex weights. Each weight has an 8-bit I part and an 8-bit Q part. Software fills, refreshes and retires entries through a plain register-style write port. A separate write port sets a default weight set. The default set must be good enough to receive a short RTS from any station.

Three protocol events make the block push a weight set to the PHY. A transmit start looks up the destination address. A received RTS looks up the sender's address. The end of a frame exchange sequence pushes the default set. A lookup that finds no entry pushes the default set and raises a miss status bit. The push is a stream of one 16-bit word per antenna, starting at antenna 0, over a valid/ready handshake. A one-cycle done pulse follows the last accepted word.

The PHY may hold `phy_ready` low on any cycle. While it does, the presented word, its antenna index and its last flag stay frozen, and the stream advances only on cycles where valid and ready are both high. Events are taken only while `evt_ready` is high, and the block never drops a word once it has presented it.

Top module: `peer_weight_table`

## Requirements
- R1: After reset no word is presented, `evt_ready` is 1, `xfer_done` and `lookup_miss` are 0, and every entry is invalid. The default set is one antenna with word 16'h7F00 (I = 127, Q = 0).
- R2: `sw_op` encodes 1 = write (address, count and weights, and marks the entry valid), 2 = update (count and weights only; the address and the valid flag are kept), 3 = invalidate, and 0 = no operation. Each operation acts on entry `sw_idx`.
- R3: A transmit start with a matching entry streams that entry's words for antennas 0 up to count-1 in order. Antenna k's word is {I, Q}, taken from `sw_wts[16k+15:16k+8]` (I) and `sw_wts[16k+7:16k]` (Q). `phy_valid` rises in the cycle after the event is taken.
- R4: A received RTS looks up `rts_src` and streams the matching entry's words in the same way as R3.
- R5: `seq_done` streams the default set. `dflt_wr` replaces the default count and weights, using the same packing as R3.
- R6: A lookup with no valid matching entry streams the default set and sets `lookup_miss`. A lookup that hits clears `lookup_miss`. `seq_done` leaves `lookup_miss` unchanged.
- R7: While `phy_valid` is high and `phy_ready` is low, `phy_word`, `phy_ant` and `phy_last` hold their values. `phy_last` is high on the final word of a set.
- R8: `xfer_done` is a single-cycle pulse in the cycle after the final word is accepted.
- R9: Events are ignored while `evt_ready` is low. When several events come in the same cycle, transmit start wins over RTS, and RTS wins over sequence end.
- R10: An antenna count of 0 is stored as 1, and a count above 4 is stored as 4. This applies to both table writes and default writes.
- R11: When several valid entries hold the same address, the lowest-numbered entry is used.
- R12: A software operation in the same cycle as a lookup is applied one cycle later. The lookup uses the table contents from before the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_op | input | 2 | Software operation code (R2) |
| sw_idx | input | 3 | Target entry |
| sw_mac | input | 48 | Peer address for a write |
| sw_cnt | input | 3 | Antenna count |
| sw_wts | input | 64 | Packed weights, 16 bits per antenna |
| dflt_wr | input | 1 | Load the default set |
| dflt_cnt | input | 3 | Default antenna count |
| dflt_wts | input | 64 | Default packed weights |
| evt_ready | output | 1 | Events are taken this cycle |
| tx_start | input | 1 | Frame about to be transmitted |
| tx_dest | input | 48 | Destination address |
| rts_seen | input | 1 | RTS received |
| rts_src | input | 48 | RTS source address |
| seq_done | input | 1 | Frame exchange sequence finished |
| phy_valid | output | 1 | Weight word valid |
| phy_ready | input | 1 | PHY accepts the word |
| phy_ant | output | 2 | Antenna index of the word |
| phy_word | output | 16 | {I, Q} weight |
| phy_last | output | 1 | Final word of the set |
| xfer_done | output | 1 | Set fully transferred |
| lookup_miss | output | 1 | Last lookup found no entry |

## Verification
On every cycle, the assertions check three things: the presented word stays frozen under back-pressure, antenna indices step up by one from zero, and the done pulse follows the final handshake and lasts one cycle with no word presented. The bench scenarios are needed for everything that depends on table contents. These are the weights chosen for each event kind, default fallback and the miss flag, lowest-entry priority, count clamping, event priority and ignoring, and the one-cycle deferral of a software write that collides with a lookup.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [1:0] {
    SW_NOP    = 2'd0,
    SW_WRITE  = 2'd1,
    SW_UPDATE = 2'd2,
    SW_INVAL  = 2'd3
  } pwt_sw_op_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_TX   = 2'd1,
    EV_RTS  = 2'd2,
    EV_END  = 2'd3
  } pwt_evt_e;
endpackage

// File: rtl/pwt_evt_arb.sv
module pwt_evt_arb
  import pwt_pkg::*;
(
  input  logic     ready,
  input  logic     tx_req,
  input  logic     rts_req,
  input  logic     end_req,
  output pwt_evt_e grant
);
  // Fixed priority: transmit, then RTS, then sequence end (R9)
  always_comb begin
    grant = EV_NONE;
    if (ready) begin
      if (tx_req)       grant = EV_TX;
      else if (rts_req) grant = EV_RTS;
      else if (end_req) grant = EV_END;
    end
  end
endmodule

// File: rtl/pwt_store.sv
module pwt_store
  import pwt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int MAC_W   = 48,
  parameter int CNT_W   = 3,
  parameter int WTS_W   = 64,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  pwt_sw_op_e         wr_op,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [MAC_W-1:0]   wr_mac,
  input  logic [CNT_W-1:0]   wr_cnt,
  input  logic [WTS_W-1:0]   wr_wts,
  input  logic [MAC_W-1:0]   lk_key,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [CNT_W-1:0]   lk_cnt,
  output logic [WTS_W-1:0]   lk_wts
);
  logic [ENTRIES-1:0] valid_q;
  logic [MAC_W-1:0]   mac_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q [ENTRIES];
  logic [WTS_W-1:0]   wts_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        mac_q[e] <= '0;
        cnt_q[e] <= CNT_W'(1);
        wts_q[e] <= '0;
      end
    end else if (wr_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_idx == IDX_W'(e)) begin
          case (wr_op)
            SW_WRITE: begin
              valid_q[e] <= 1'b1;
              mac_q[e]   <= wr_mac;
              cnt_q[e]   <= wr_cnt;
              wts_q[e]   <= wr_wts;
            end
            SW_UPDATE: begin
              cnt_q[e] <= wr_cnt;
              wts_q[e] <= wr_wts;
            end
            SW_INVAL: valid_q[e] <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  // One comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (mac_q[g] == lk_key);
  end

  // Lowest matching index wins (R11)
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        lk_hit = 1'b1;
        lk_idx = IDX_W'(e);
      end
    end
  end

  assign lk_cnt = cnt_q[lk_idx];
  assign lk_wts = wts_q[lk_idx];
endmodule

// File: rtl/pwt_stream.sv
module pwt_stream #(
  parameter int CNT_W  = 3,
  parameter int AW     = 2,
  parameter int WORD_W = 16,
  parameter int WTS_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [WTS_W-1:0]  load_wts,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_ant,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic              done
);
  logic              busy_q;
  logic [AW-1:0]     idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WTS_W-1:0]  wts_q;
  logic              done_q;
  logic              take;

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_ant   = idx_q;
  assign out_word  = wts_q[int'(idx_q) * WORD_W +: WORD_W];
  assign out_last  = (CNT_W'(idx_q) == cnt_q - CNT_W'(1));
  assign take      = busy_q && out_ready;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= CNT_W'(1);
      wts_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take && out_last;
      if (load && !busy_q) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cnt_q  <= load_cnt;
        wts_q  <= load_wts;
      end else if (take) begin
        if (out_last) busy_q <= 1'b0;
        else          idx_q  <= idx_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/peer_weight_table.sv
module peer_weight_table
  import pwt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int MAC_W   = 48,
  parameter int MAX_ANT = 4,
  parameter int CW      = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         sw_op,
  input  logic [$clog2(ENTRIES)-1:0]         sw_idx,
  input  logic [MAC_W-1:0]                   sw_mac,
  input  logic [$clog2(MAX_ANT+1)-1:0]       sw_cnt,
  input  logic [MAX_ANT*2*CW-1:0]            sw_wts,
  input  logic                               dflt_wr,
  input  logic [$clog2(MAX_ANT+1)-1:0]       dflt_cnt,
  input  logic [MAX_ANT*2*CW-1:0]            dflt_wts,
  output logic                               evt_ready,
  input  logic                               tx_start,
  input  logic [MAC_W-1:0]                   tx_dest,
  input  logic                               rts_seen,
  input  logic [MAC_W-1:0]                   rts_src,
  input  logic                               seq_done,
  output logic                               phy_valid,
  input  logic                               phy_ready,
  output logic [$clog2(MAX_ANT)-1:0]         phy_ant,
  output logic [2*CW-1:0]                    phy_word,
  output logic                               phy_last,
  output logic                               xfer_done,
  output logic                               lookup_miss
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(MAX_ANT + 1);
  localparam int AW     = $clog2(MAX_ANT);
  localparam int WORD_W = 2 * CW;
  localparam int WTS_W  = MAX_ANT * WORD_W;
  localparam logic [WTS_W-1:0] DFLT_RST = WTS_W'((2 ** (CW - 1)) - 1) << CW;

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
    if (c == '0) return CNT_W'(1);
    if (c > CNT_W'(MAX_ANT)) return CNT_W'(MAX_ANT);
    return c;
  endfunction

  // Event selection
  pwt_evt_e grant;
  logic     busy;
  logic     do_lookup;
  logic     pend_v;

  assign evt_ready = !busy && !pend_v;
  assign do_lookup = (grant == EV_TX) || (grant == EV_RTS);

  pwt_evt_arb u_arb (
    .ready   (evt_ready),
    .tx_req  (tx_start),
    .rts_req (rts_seen),
    .end_req (seq_done),
    .grant   (grant)
  );

  // Software operation with one-slot deferral (R12)
  pwt_sw_op_e         in_op;
  logic               in_v;
  pwt_sw_op_e         pend_op;
  logic [IDX_W-1:0]   pend_idx;
  logic [MAC_W-1:0]   pend_mac;
  logic [CNT_W-1:0]   pend_cnt;
  logic [WTS_W-1:0]   pend_wts;
  logic               defer;

  assign in_op = pwt_sw_op_e'(sw_op);
  assign in_v  = (in_op != SW_NOP);
  assign defer = in_v && (pend_v || do_lookup);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_op  <= SW_NOP;
      pend_idx <= '0;
      pend_mac <= '0;
      pend_cnt <= CNT_W'(1);
      pend_wts <= '0;
    end else begin
      pend_v <= defer;
      if (defer) begin
        pend_op  <= in_op;
        pend_idx <= sw_idx;
        pend_mac <= sw_mac;
        pend_cnt <= sw_cnt;
        pend_wts <= sw_wts;
      end
    end
  end

  logic               wr_en;
  pwt_sw_op_e         wr_op;
  logic [IDX_W-1:0]   wr_idx;
  logic [MAC_W-1:0]   wr_mac;
  logic [CNT_W-1:0]   wr_cnt;
  logic [WTS_W-1:0]   wr_wts;

  always_comb begin
    if (pend_v) begin
      wr_en  = 1'b1;
      wr_op  = pend_op;
      wr_idx = pend_idx;
      wr_mac = pend_mac;
      wr_cnt = clamp_cnt(pend_cnt);
      wr_wts = pend_wts;
    end else begin
      wr_en  = in_v && !do_lookup;
      wr_op  = in_op;
      wr_idx = sw_idx;
      wr_mac = sw_mac;
      wr_cnt = clamp_cnt(sw_cnt);
      wr_wts = sw_wts;
    end
  end

  // Table
  logic [MAC_W-1:0] lk_key;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic [CNT_W-1:0] lk_cnt;
  logic [WTS_W-1:0] lk_wts;

  assign lk_key = (grant == EV_RTS) ? rts_src : tx_dest;

  pwt_store #(
    .ENTRIES (ENTRIES),
    .MAC_W   (MAC_W),
    .CNT_W   (CNT_W),
    .WTS_W   (WTS_W),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_op  (wr_op),
    .wr_idx (wr_idx),
    .wr_mac (wr_mac),
    .wr_cnt (wr_cnt),
    .wr_wts (wr_wts),
    .lk_key (lk_key),
    .lk_hit (lk_hit),
    .lk_idx (lk_idx),
    .lk_cnt (lk_cnt),
    .lk_wts (lk_wts)
  );

  // Default set and miss status
  logic [CNT_W-1:0] dflt_cnt_q;
  logic [WTS_W-1:0] dflt_wts_q;
  logic             miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_cnt_q <= CNT_W'(1);
      dflt_wts_q <= DFLT_RST;
      miss_q     <= 1'b0;
    end else begin
      if (dflt_wr) begin
        dflt_cnt_q <= clamp_cnt(dflt_cnt);
        dflt_wts_q <= dflt_wts;
      end
      if (do_lookup) miss_q <= !lk_hit;
    end
  end

  assign lookup_miss = miss_q;

  // Weight set selection and streaming
  logic             use_entry;
  logic [CNT_W-1:0] set_cnt;
  logic [WTS_W-1:0] set_wts;

  assign use_entry = do_lookup && lk_hit;
  assign set_cnt   = use_entry ? lk_cnt : dflt_cnt_q;
  assign set_wts   = use_entry ? lk_wts : dflt_wts_q;

  pwt_stream #(
    .CNT_W  (CNT_W),
    .AW     (AW),
    .WORD_W (WORD_W),
    .WTS_W  (WTS_W)
  ) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (grant != EV_NONE),
    .load_cnt  (set_cnt),
    .load_wts  (set_wts),
    .busy      (busy),
    .out_valid (phy_valid),
    .out_ready (phy_ready),
    .out_ant   (phy_ant),
    .out_word  (phy_word),
    .out_last  (phy_last),
    .done      (xfer_done)
  );
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int MAX_ANT = 4,
  parameter int CW      = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       phy_valid,
  input logic                       phy_ready,
  input logic [$clog2(MAX_ANT)-1:0] phy_ant,
  input logic [2*CW-1:0]            phy_word,
  input logic                       phy_last,
  input logic                       xfer_done
);
  localparam int AW = $clog2(MAX_ANT);

  // R7: stalled word is frozen
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    phy_valid && !phy_ready |=> phy_valid && $stable(phy_word) && $stable(phy_ant) && $stable(phy_last));

  // R3: each set starts at antenna 0
  a_r3_first_ant_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_valid) |-> phy_ant == '0);

  // R3: antenna index steps by one inside a set
  a_r3_ant_step: assert property (@(posedge clk) disable iff (!rst_n)
    phy_valid && phy_ready && !phy_last |=> phy_valid && (phy_ant == AW'($past(phy_ant) + 1'b1)));

  // R8: done follows the final handshake
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    phy_valid && phy_ready && phy_last |=> xfer_done);

  // R8: done is a single-cycle pulse with no word presented
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !phy_valid);
endmodule

bind peer_weight_table pwt_checker #(.MAX_ANT(MAX_ANT), .CW(CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .phy_valid (phy_valid),
  .phy_ready (phy_ready),
  .phy_ant   (phy_ant),
  .phy_word  (phy_word),
  .phy_last  (phy_last),
  .xfer_done (xfer_done)
);

// File: tb/peer_weight_table_tb_top.sv
module peer_weight_table_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sw_op = '0;
  logic [2:0]  sw_idx = '0;
  logic [47:0] sw_mac = '0;
  logic [2:0]  sw_cnt = '0;
  logic [63:0] sw_wts = '0;
  logic        dflt_wr = 1'b0;
  logic [2:0]  dflt_cnt = '0;
  logic [63:0] dflt_wts = '0;
  logic        evt_ready;
  logic        tx_start = 1'b0;
  logic [47:0] tx_dest = '0;
  logic        rts_seen = 1'b0;
  logic [47:0] rts_src = '0;
  logic        seq_done = 1'b0;
  logic        phy_valid;
  logic        phy_ready = 1'b1;
  logic [1:0]  phy_ant;
  logic [15:0] phy_word;
  logic        phy_last;
  logic        xfer_done;
  logic        lookup_miss;

  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  peer_weight_table dut_i (.*);

  // Handshake collector
  logic [15:0] got_w[$];
  int          got_a[$];
  bit          got_l[$];
  always @(posedge clk) begin
    if (phy_valid && phy_ready) begin
      got_w.push_back(phy_word);
      got_a.push_back(int'(phy_ant));
      got_l.push_back(phy_last);
    end
  end

  // Ready driver, optionally pseudo-random
  bit       bp = 1'b0;
  logic [7:0] lf = 8'h5A;
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    phy_ready = bp ? lf[0] : 1'b1;
  end

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'hA0B1_C2D3_E4F5;
  localparam logic [47:0] MAC_C = 48'h7777_0000_1234;
  localparam logic [47:0] MAC_D = 48'h0D0D_0D0D_0D0D;
  localparam logic [47:0] MAC_E = 48'hEEEE_EEEE_0001;

  function automatic logic [63:0] mkw(input logic [7:0] b);
    logic [63:0] w;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] i;
      i = b + 8'(k);
      w[k*16 +: 16] = {i, ~i};
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sw(input logic [1:0] op, input logic [2:0] idx, input logic [47:0] mac,
                    input logic [2:0] cnt, input logic [63:0] w);
    @(negedge clk);
    sw_op = op; sw_idx = idx; sw_mac = mac; sw_cnt = cnt; sw_wts = w;
    @(negedge clk);
    sw_op = '0;
  endtask

  task automatic set_default(input logic [2:0] cnt, input logic [63:0] w);
    @(negedge clk);
    dflt_wr = 1'b1; dflt_cnt = cnt; dflt_wts = w;
    @(negedge clk);
    dflt_wr = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!xfer_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen"}, 64'(xfer_done), 64'd1);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, 64'(xfer_done), 64'd0);
  endtask

  task automatic fire(input string tag, input bit a_tx, input bit a_rts, input bit a_end,
                      input logic [47:0] m_tx, input logic [47:0] m_rts,
                      input bit col, input logic [2:0] c_idx, input logic [47:0] c_mac,
                      input logic [2:0] c_cnt, input logic [63:0] c_wts);
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    got_w.delete(); got_a.delete(); got_l.delete();
    tx_start = a_tx; rts_seen = a_rts; seq_done = a_end;
    tx_dest = m_tx; rts_src = m_rts;
    if (col) begin
      sw_op = 2'd1; sw_idx = c_idx; sw_mac = c_mac; sw_cnt = c_cnt; sw_wts = c_wts;
    end
    @(negedge clk);
    tx_start = 1'b0; rts_seen = 1'b0; seq_done = 1'b0; sw_op = '0;
    chk({tag, " R3 valid next cycle"}, {62'd0, phy_valid, phy_ant == 2'd0}, 64'd3);
    wait_done(tag);
  endtask

  task automatic expect_set(input string tag, input int n, input logic [63:0] w);
    chk({tag, " word count"}, 64'(got_w.size()), 64'(n));
    for (int k = 0; k < n && k < got_w.size(); k++) begin
      chk($sformatf("%s word %0d", tag, k), {got_w[k], 8'(got_a[k]), 7'd0, got_l[k]},
          {w[k*16 +: 16], 8'(k), 7'd0, k == n - 1});
    end
  endtask

  // Scenarios
  task automatic t_reset();
    chk("R1 reset outputs", {60'd0, evt_ready, phy_valid, xfer_done, lookup_miss}, 64'b1000);
    fire("R1 default", 0, 0, 1, '0, '0, 0, '0, '0, '0, '0);
    expect_set("R1 default reset set", 1, 64'h7F00);
    fire("R1 empty table", 1, 0, 0, MAC_A, '0, 0, '0, '0, '0, '0);
    expect_set("R1 all invalid", 1, 64'h7F00);
    chk("R1 miss on empty", 64'(lookup_miss), 64'd1);
  endtask

  task automatic t_tx_hit();
    sw(2'd1, 3'd0, MAC_A, 3'd4, mkw(8'h10));
    fire("R3 tx", 1, 0, 0, MAC_A, '0, 0, '0, '0, '0, '0);
    expect_set("R3 tx hit", 4, mkw(8'h10));
    chk("R6 hit clears miss", 64'(lookup_miss), 64'd0);
  endtask

  task automatic t_rts_hit();
    sw(2'd1, 3'd3, MAC_B, 3'd2, mkw(8'h40));
    fire("R4 rts", 0, 1, 0, '0, MAC_B, 0, '0, '0, '0, '0);
    expect_set("R4 rts hit", 2, mkw(8'h40));
  endtask

  task automatic t_miss_default();
    fire("R6 miss", 1, 0, 0, MAC_C, '0, 0, '0, '0, '0, '0);
    expect_set("R6 miss default", 1, 64'h7F00);
    chk("R6 miss set", 64'(lookup_miss), 64'd1);
    set_default(3'd3, mkw(8'h70));
    fire("R5 end", 0, 0, 1, '0, '0, 0, '0, '0, '0, '0);
    expect_set("R5 new default", 3, mkw(8'h70));
    chk("R6 end keeps miss", 64'(lookup_miss), 64'd1);
  endtask

  task automatic t_update_inval();
    sw(2'd2, 3'd0, MAC_C, 3'd1, mkw(8'h20));
    fire("R2 update", 1, 0, 0, MAC_A, '0, 0, '0, '0, '0, '0);
    expect_set("R2 update keeps address", 1, mkw(8'h20));
    sw(2'd3, 3'd3, '0, '0, '0);
    fire("R2 inval", 0, 1, 0, '0, MAC_B, 0, '0, '0, '0, '0);
    expect_set("R2 invalidated entry", 3, mkw(8'h70));
    chk("R2 invalidated miss", 64'(lookup_miss), 64'd1);
  endtask

  task automatic t_clamp();
    sw(2'd1, 3'd1, MAC_D, 3'd0, mkw(8'h30));
    fire("R10 zero", 1, 0, 0, MAC_D, '0, 0, '0, '0, '0, '0);
    expect_set("R10 count 0 as 1", 1, mkw(8'h30));
    sw(2'd1, 3'd1, MAC_D, 3'd7, mkw(8'h31));
    fire("R10 big", 1, 0, 0, MAC_D, '0, 0, '0, '0, '0, '0);
    expect_set("R10 count 7 as 4", 4, mkw(8'h31));
    set_default(3'd6, mkw(8'h60));
    fire("R10 dflt", 0, 0, 1, '0, '0, 0, '0, '0, '0, '0);
    expect_set("R10 default count clamp", 4, mkw(8'h60));
  endtask

  task automatic t_duplicate();
    sw(2'd1, 3'd5, MAC_E, 3'd2, mkw(8'h55));
    sw(2'd1, 3'd2, MAC_E, 3'd3, mkw(8'h22));
    fire("R11 dup", 1, 0, 0, MAC_E, '0, 0, '0, '0, '0, '0);
    expect_set("R11 lowest entry", 3, mkw(8'h22));
  endtask

  task automatic t_priority_ignore();
    sw(2'd1, 3'd3, MAC_B, 3'd2, mkw(8'h40));
    fire("R9 prio", 1, 1, 1, MAC_A, MAC_B, 0, '0, '0, '0, '0);
    expect_set("R9 tx wins", 1, mkw(8'h20));
    fire("R9 rts over end", 0, 1, 1, '0, MAC_B, 0, '0, '0, '0, '0);
    expect_set("R9 rts wins", 2, mkw(8'h40));
    // Event during a transfer is dropped
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    got_w.delete(); got_a.delete(); got_l.delete();
    tx_start = 1'b1; tx_dest = MAC_D;
    @(negedge clk);
    tx_start = 1'b0;
    chk("R9 busy ready low", 64'(evt_ready), 64'd0);
    rts_seen = 1'b1; rts_src = MAC_B;
    @(negedge clk);
    rts_seen = 1'b0;
    wait_done("R9 busy");
    begin
      bit seen = 1'b0;
      for (int c = 0; c < 6; c++) begin
        if (phy_valid) seen = 1'b1;
        @(negedge clk);
      end
      chk("R9 busy event ignored", {63'd0, seen}, 64'd0);
    end
    expect_set("R9 only first set", 4, mkw(8'h31));
  endtask

  task automatic t_backpressure();
    bp = 1'b1;
    fire("R7 bp", 1, 0, 0, MAC_D, '0, 0, '0, '0, '0, '0);
    expect_set("R7 stream under back-pressure", 4, mkw(8'h31));
    fire("R7 bp rts", 0, 1, 0, '0, MAC_B, 0, '0, '0, '0, '0);
    expect_set("R7 rts under back-pressure", 2, mkw(8'h40));
    bp = 1'b0;
  endtask

  task automatic t_collision();
    fire("R12 col", 1, 0, 0, MAC_A, '0, 1, 3'd0, MAC_A, 3'd2, mkw(8'h90));
    expect_set("R12 lookup sees old entry", 1, mkw(8'h20));
    fire("R12 after", 1, 0, 0, MAC_A, '0, 0, '0, '0, '0, '0);
    expect_set("R12 deferred write applied", 2, mkw(8'h90));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_hit();
    t_rts_hit();
    t_miss_default();
    t_update_inval();
    t_clamp();
    t_duplicate();
    t_priority_ignore();
    t_backpressure();
    t_collision();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule